// File: doc/BRIEF.md
# MMU Register Move Command Decoder

This block sits beside a processor core's coprocessor interface and handles the MMU command group. Each cycle that `cmd_valid` is high, it takes a 16-bit opcode and a 16-bit extension word and works out what kind of command they form. Register moves are carried out on the spot. A move either loads an MMU register from `wr_data` or returns that register's value on `rd_data`. The registers are:

- the translation-control word, whose top bit drives the MMU enable;
- two 64-bit root pointers, one for supervisor and one for the CPU;
- a status word.

Cache-control, probe and branch encodings are recognised and reported as unimplemented, and the block performs none of them. Effective-address decoding is left to the surrounding core: the 6-bit addressing field of the opcode is simply handed back on `ea_field`.

Results come back one clock after the command. `done` pulses for that cycle, and it comes with an outcome code and a command-kind code. The core uses the outcome to decide whether to take an exception. When the move was a read, it uses `rd_data` as the value to store.

Top module: `mmu_cmd_decoder`

## Requirements
- R1: An opcode is a branch form when `opcode & 0xFFC0` equals 0xF0C0 or 0xF080. This check comes before any other, and the result is outcome 1 (unhandled) with kind 1 (branch).
- R2: For any other opcode, a nonzero family field `opcode[11:9]` gives outcome 2 (unknown group) and kind 0.
- R3: In family 0 the extension word is tested in a fixed order. The first match wins, gives outcome 1 (unhandled), and changes no register:

  | Order | Test on the extension word | Kind |
  |---|---|---|
  | 1 | `ext & 0xFDE0 == 0x2000` | 2 |
  | 2 | `ext & 0xE200 == 0x2000` | 3 |
  | 3 | `ext == 0xA000` | 4 |
  | 4 | `ext == 0x2800` | 5 |
  | 5 | `ext & 0xFFF8 == 0x2C00` | 6 |
  | 6 | `ext & 0xE000 == 0x8000` | 7 |

  Because of this order, 0x2800 and 0x2C0x both report kind 3.
- R4: Otherwise, `ext[15:13]` selects the move mode:
  - 0 or 2 is a general register move, kind 8;
  - 3 is a status-word move, kind 9, and ignores `ext[12:10]`;
  - any other value gives outcome 3 (unknown mode) and kind 0.
- R5: `ext[9]` sets the direction of a move. A 1 reads the register out to `rd_data`; a 0 writes `wr_data` into the register.
- R6: In a general move, `ext[12:10]` picks the register: 0 is the translation-control word, 2 the supervisor root pointer, 3 the CPU root pointer. Any other value gives outcome 4 (unknown register) with kind 8, and no register changes.
- R7: A root pointer moves as 64 bits, with the limit in bits 63:32 and the table address in bits 31:0. The control word and the status word use bits 31:0, and they read back with bits 63:32 zero.
- R8: `mmu_enable` equals bit 31 of the most recently written control word. It changes in the cycle after that write, and at no other time except reset.
- R9: `ea_field` presents `opcode[5:0]` of the last command, one cycle after that command.
- R10: For each command, `done` is high for exactly the one following cycle, with outcome 0 (moved) for a completed move. `rd_data` is nonzero only after a read move.
- R11: Reset clears all MMU registers and outputs, so `mmu_enable` is 0, `done` is 0, and every code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| opcode | input | 16 | Instruction word |
| ext_word | input | 16 | Extension word |
| wr_data | input | 64 | Value to load on a write move |
| done | output | 1 | One-cycle completion pulse |
| outcome | output | 3 | 0 moved, 1 unhandled, 2 unknown group, 3 unknown mode, 4 unknown register |
| cmd_kind | output | 4 | Decoded command class (codes in R1, R3, R4) |
| ea_field | output | 6 | Addressing field of the opcode |
| rd_data | output | 64 | Register value from a read move, else zero |
| mmu_enable | output | 1 | Translation enable from the control word |

## Verification
Several properties are checked by the assertions on every cycle:

- the single-cycle `done` pulse that follows each command;
- the branch and unknown-group classifications, which come from the opcode alone;
- the pass-through of the addressing field;
- the zero on `rd_data` for anything other than a completed move;
- the constancy of `mmu_enable` when no command arrives.

Other behaviour depends on stored state or on the order of the extension-word tests, so only the bench's command sequences can show it. This covers values surviving a round trip through each register in both directions, and unknown-register and unhandled commands leaving the registers unchanged. It also covers the shadowing of the two validate encodings by the flush pattern, and the enable following bit 31 on writes that set it and then clear it.

// File: rtl/mmu_cmd_pkg.sv
package mmu_cmd_pkg;

   typedef enum logic [2:0] {
      OUT_MOVED     = 3'd0,
      OUT_UNHANDLED = 3'd1,
      OUT_UNK_GROUP = 3'd2,
      OUT_UNK_MODE  = 3'd3,
      OUT_UNK_REG   = 3'd4
   } outcome_e;

   typedef enum logic [3:0] {
      KIND_NONE        = 4'd0,
      KIND_BRANCH      = 4'd1,
      KIND_LOAD_ENTRY  = 4'd2,
      KIND_FLUSH       = 4'd3,
      KIND_FLUSH_ROOT  = 4'd4,
      KIND_VALIDATE_A  = 4'd5,
      KIND_VALIDATE_B  = 4'd6,
      KIND_PROBE       = 4'd7,
      KIND_MOVE_GEN    = 4'd8,
      KIND_MOVE_STATUS = 4'd9
   } kind_e;

   typedef enum logic [2:0] {
      SEL_NONE = 3'd0,
      SEL_CTRL = 3'd1,
      SEL_SUPV = 3'd2,
      SEL_CPU  = 3'd3,
      SEL_STAT = 3'd4
   } reg_sel_e;

   // opcode patterns for the branch forms
   localparam logic [15:0] BR_MASK  = 16'hFFC0;
   localparam logic [15:0] BR_VAL_A = 16'hF0C0;
   localparam logic [15:0] BR_VAL_B = 16'hF080;

   // extension-word patterns, listed in priority order
   localparam logic [15:0] LOAD_MASK   = 16'hFDE0;
   localparam logic [15:0] LOAD_VAL    = 16'h2000;
   localparam logic [15:0] FLUSH_MASK  = 16'hE200;
   localparam logic [15:0] FLUSH_VAL   = 16'h2000;
   localparam logic [15:0] FROOT_VAL   = 16'hA000;
   localparam logic [15:0] VALA_VAL    = 16'h2800;
   localparam logic [15:0] VALB_MASK   = 16'hFFF8;
   localparam logic [15:0] VALB_VAL    = 16'h2C00;
   localparam logic [15:0] PROBE_MASK  = 16'hE000;
   localparam logic [15:0] PROBE_VAL   = 16'h8000;

endpackage

// File: rtl/mmu_cmd_classify.sv
module mmu_cmd_classify
   import mmu_cmd_pkg::*;
#(
   parameter int OPC_W      = 16,
   parameter int EXT_W      = 16,
   parameter bit HAS_STATUS = 1'b1
) (
   input  logic [OPC_W-1:0] opcode,
   input  logic [EXT_W-1:0] ext_word,
   output outcome_e         cls_outcome,
   output kind_e            cls_kind,
   output reg_sel_e         cls_sel,
   output logic             cls_read
);

   localparam int FAM_LO  = 9;
   localparam int FAM_HI  = 11;
   localparam int MODE_LO = 13;
   localparam int REG_LO  = 10;
   localparam int DIR_BIT = 9;

   if (OPC_W != 16) begin : g_opc_chk
      $error("mmu_cmd_classify: OPC_W must be 16");
   end
   if (EXT_W != 16) begin : g_ext_chk
      $error("mmu_cmd_classify: EXT_W must be 16");
   end

   logic       is_branch;
   logic [2:0] family;
   logic [2:0] mode;
   logic [2:0] regf;

   assign is_branch = ((opcode & BR_MASK) == BR_VAL_A) ||
                      ((opcode & BR_MASK) == BR_VAL_B);
   assign family    = opcode[FAM_HI:FAM_LO];
   assign mode      = ext_word[MODE_LO+2:MODE_LO];
   assign regf      = ext_word[REG_LO+2:REG_LO];
   assign cls_read  = ext_word[DIR_BIT];

   always_comb begin
      cls_outcome = OUT_MOVED;
      cls_kind    = KIND_NONE;
      cls_sel     = SEL_NONE;
      if (is_branch) begin
         cls_outcome = OUT_UNHANDLED;
         cls_kind    = KIND_BRANCH;
      end else if (family != 3'd0) begin
         cls_outcome = OUT_UNK_GROUP;
      end else if ((ext_word & LOAD_MASK) == LOAD_VAL) begin
         cls_outcome = OUT_UNHANDLED;
         cls_kind    = KIND_LOAD_ENTRY;
      end else if ((ext_word & FLUSH_MASK) == FLUSH_VAL) begin
         cls_outcome = OUT_UNHANDLED;
         cls_kind    = KIND_FLUSH;
      end else if (ext_word == FROOT_VAL) begin
         cls_outcome = OUT_UNHANDLED;
         cls_kind    = KIND_FLUSH_ROOT;
      end else if (ext_word == VALA_VAL) begin
         cls_outcome = OUT_UNHANDLED;
         cls_kind    = KIND_VALIDATE_A;
      end else if ((ext_word & VALB_MASK) == VALB_VAL) begin
         cls_outcome = OUT_UNHANDLED;
         cls_kind    = KIND_VALIDATE_B;
      end else if ((ext_word & PROBE_MASK) == PROBE_VAL) begin
         cls_outcome = OUT_UNHANDLED;
         cls_kind    = KIND_PROBE;
      end else begin
         case (mode)
            3'd0, 3'd2: begin
               cls_kind = KIND_MOVE_GEN;
               case (regf)
                  3'd0:    cls_sel = SEL_CTRL;
                  3'd2:    cls_sel = SEL_SUPV;
                  3'd3:    cls_sel = SEL_CPU;
                  default: cls_outcome = OUT_UNK_REG;
               endcase
            end
            3'd3: begin
               if (HAS_STATUS) begin
                  cls_kind = KIND_MOVE_STATUS;
                  cls_sel  = SEL_STAT;
               end else begin
                  cls_outcome = OUT_UNK_MODE;
               end
            end
            default: cls_outcome = OUT_UNK_MODE;
         endcase
      end
   end

endmodule

// File: rtl/mmu_reg_bank.sv
module mmu_reg_bank
   import mmu_cmd_pkg::*;
#(
   parameter int  REG_W      = 32,
   parameter int  DATA_W     = 64,
   parameter bit  HAS_STATUS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  reg_sel_e          sel,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_value,
   output logic              enable
);

   localparam int ENABLE_BIT = REG_W - 1;

   if (DATA_W != 2 * REG_W) begin : g_width_chk
      $error("mmu_reg_bank: DATA_W must be twice REG_W");
   end

   logic [REG_W-1:0] wr_lo;
   logic [REG_W-1:0] wr_hi;
   logic [REG_W-1:0] ctrl_q;
   logic [REG_W-1:0] supv_lim_q;
   logic [REG_W-1:0] supv_ptr_q;
   logic [REG_W-1:0] cpu_lim_q;
   logic [REG_W-1:0] cpu_ptr_q;
   logic [REG_W-1:0] stat_val;

   assign wr_lo = wr_data[REG_W-1:0];
   assign wr_hi = wr_data[DATA_W-1:REG_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q     <= '0;
         supv_lim_q <= '0;
         supv_ptr_q <= '0;
         cpu_lim_q  <= '0;
         cpu_ptr_q  <= '0;
      end else if (wr_en) begin
         case (sel)
            SEL_CTRL: ctrl_q <= wr_lo;
            SEL_SUPV: begin
               supv_lim_q <= wr_hi;
               supv_ptr_q <= wr_lo;
            end
            SEL_CPU: begin
               cpu_lim_q <= wr_hi;
               cpu_ptr_q <= wr_lo;
            end
            default: ;
         endcase
      end
   end

   if (HAS_STATUS) begin : g_status
      logic [REG_W-1:0] stat_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            stat_q <= '0;
         end else if (wr_en && sel == SEL_STAT) begin
            stat_q <= wr_lo;
         end
      end
      assign stat_val = stat_q;
   end else begin : g_no_status
      assign stat_val = '0;
   end

   always_comb begin
      case (sel)
         SEL_CTRL: rd_value = {{REG_W{1'b0}}, ctrl_q};
         SEL_SUPV: rd_value = {supv_lim_q, supv_ptr_q};
         SEL_CPU:  rd_value = {cpu_lim_q, cpu_ptr_q};
         SEL_STAT: rd_value = {{REG_W{1'b0}}, stat_val};
         default:  rd_value = '0;
      endcase
   end

   assign enable = ctrl_q[ENABLE_BIT];

endmodule

// File: rtl/mmu_cmd_decoder.sv
module mmu_cmd_decoder
   import mmu_cmd_pkg::*;
#(
   parameter int OPC_W      = 16,
   parameter int EXT_W      = 16,
   parameter int REG_W      = 32,
   parameter int EA_W       = 6,
   parameter bit HAS_STATUS = 1'b1,
   localparam int DATA_W    = 2 * REG_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [OPC_W-1:0]  opcode,
   input  logic [EXT_W-1:0]  ext_word,
   input  logic [DATA_W-1:0] wr_data,
   output logic              done,
   output logic [2:0]        outcome,
   output logic [3:0]        cmd_kind,
   output logic [EA_W-1:0]   ea_field,
   output logic [DATA_W-1:0] rd_data,
   output logic              mmu_enable
);

   if (EA_W > 9) begin : g_ea_chk
      $error("mmu_cmd_decoder: EA_W overlaps the family field");
   end

   outcome_e          cls_outcome;
   kind_e             cls_kind;
   reg_sel_e          cls_sel;
   logic              cls_read;
   logic              moved;
   logic              bank_wr;
   logic [DATA_W-1:0] bank_rd;

   mmu_cmd_classify #(
      .OPC_W      (OPC_W),
      .EXT_W      (EXT_W),
      .HAS_STATUS (HAS_STATUS)
   ) i_classify (
      .opcode      (opcode),
      .ext_word    (ext_word),
      .cls_outcome (cls_outcome),
      .cls_kind    (cls_kind),
      .cls_sel     (cls_sel),
      .cls_read    (cls_read)
   );

   assign moved   = (cls_outcome == OUT_MOVED);
   assign bank_wr = cmd_valid && moved && !cls_read;

   mmu_reg_bank #(
      .REG_W      (REG_W),
      .DATA_W     (DATA_W),
      .HAS_STATUS (HAS_STATUS)
   ) i_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (bank_wr),
      .sel      (cls_sel),
      .wr_data  (wr_data),
      .rd_value (bank_rd),
      .enable   (mmu_enable)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done     <= 1'b0;
         outcome  <= '0;
         cmd_kind <= '0;
         ea_field <= '0;
         rd_data  <= '0;
      end else begin
         done <= cmd_valid;
         if (cmd_valid) begin
            outcome  <= cls_outcome;
            cmd_kind <= cls_kind;
            ea_field <= opcode[EA_W-1:0];
            rd_data  <= (moved && cls_read) ? bank_rd : '0;
         end
      end
   end

endmodule

// File: rtl/mmu_cmd_decoder_chk.sv
module mmu_cmd_decoder_chk #(
   parameter int OPC_W  = 16,
   parameter int EA_W   = 6,
   parameter int DATA_W = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid,
   input logic [OPC_W-1:0]  opcode,
   input logic              done,
   input logic [2:0]        outcome,
   input logic [3:0]        cmd_kind,
   input logic [EA_W-1:0]   ea_field,
   input logic [DATA_W-1:0] rd_data,
   input logic              mmu_enable
);

   logic is_br;
   assign is_br = ((opcode & 16'hFFC0) == 16'hF0C0) || ((opcode & 16'hFFC0) == 16'hF080);

   AST_BRANCH_UNHANDLED: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && is_br |=> outcome == 3'd1 && cmd_kind == 4'd1); // R1

   AST_UNKNOWN_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !is_br && opcode[11:9] != 3'd0 |=> outcome == 3'd2 && cmd_kind == 4'd0); // R2

   AST_ENABLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |=> $stable(mmu_enable)); // R8

   AST_EA_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> ea_field == $past(opcode[EA_W-1:0])); // R9

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> done); // R10

   AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |=> !done); // R10

   AST_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      done && outcome != 3'd0 |-> rd_data == '0); // R10

endmodule

bind mmu_cmd_decoder mmu_cmd_decoder_chk #(
   .OPC_W  (OPC_W),
   .EA_W   (EA_W),
   .DATA_W (DATA_W)
) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cmd_valid  (cmd_valid),
   .opcode     (opcode),
   .done       (done),
   .outcome    (outcome),
   .cmd_kind   (cmd_kind),
   .ea_field   (ea_field),
   .rd_data    (rd_data),
   .mmu_enable (mmu_enable)
);

// File: tb/test_mmu_cmd_decoder.sv
`timescale 1ns/1ps
module test_mmu_cmd_decoder;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [15:0] opcode = '0;
   logic [15:0] ext_word = '0;
   logic [63:0] wr_data = '0;
   logic        done;
   logic [2:0]  outcome;
   logic [3:0]  cmd_kind;
   logic [5:0]  ea_field;
   logic [63:0] rd_data;
   logic        mmu_enable;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   mmu_cmd_decoder i_mmu_cmd_decoder (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .opcode(opcode),
      .ext_word(ext_word), .wr_data(wr_data), .done(done), .outcome(outcome),
      .cmd_kind(cmd_kind), .ea_field(ea_field), .rd_data(rd_data),
      .mmu_enable(mmu_enable)
   );

   typedef struct packed {
      logic [15:0] opc;
      logic [15:0] ext;
      logic [63:0] wd;
      logic [2:0]  out;
      logic [3:0]  kind;
      logic [63:0] rd;
      logic        en;
   } vec_t;

   localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
   localparam int NV = 26;
   localparam vec_t VECS [NV] = '{
      '{16'hF005, 16'h0000, 64'h0000_0000_8000_1234, 3'd0, 4'd8, 64'h0, 1'b1},
      '{16'hF006, 16'h0200, ONES,                   3'd0, 4'd8, 64'h0000_0000_8000_1234, 1'b1},
      '{16'hF007, 16'h0800, 64'h1111_2222_3333_4440, 3'd0, 4'd8, 64'h0, 1'b1},
      '{16'hF008, 16'h0A00, 64'h0,                  3'd0, 4'd8, 64'h1111_2222_3333_4440, 1'b1},
      '{16'hF009, 16'h4C00, 64'hAAAA_0003_0000_1000, 3'd0, 4'd8, 64'h0, 1'b1},
      '{16'hF00A, 16'h0E00, 64'h0,                  3'd0, 4'd8, 64'hAAAA_0003_0000_1000, 1'b1},
      '{16'hF00B, 16'h6000, 64'hFFFF_FFFF_0000_00C3, 3'd0, 4'd9, 64'h0, 1'b1},
      '{16'hF00C, 16'h7E00, 64'h0,                  3'd0, 4'd9, 64'h0000_0000_0000_00C3, 1'b1},
      '{16'hF00D, 16'h0400, 64'hDEAD_BEEF_0000_0000, 3'd4, 4'd8, 64'h0, 1'b1},
      '{16'hF00E, 16'h1E00, 64'h0,                  3'd4, 4'd8, 64'h0, 1'b1},
      '{16'hF00F, 16'h0200, 64'h0,                  3'd0, 4'd8, 64'h0000_0000_8000_1234, 1'b1},
      '{16'hF010, 16'h2600, ONES,                   3'd3, 4'd0, 64'h0, 1'b1},
      '{16'hF011, 16'hC000, ONES,                   3'd3, 4'd0, 64'h0, 1'b1},
      '{16'hF0C5, 16'h0000, 64'h0,                  3'd1, 4'd1, 64'h0, 1'b1},
      '{16'hF08A, 16'h0000, 64'h0,                  3'd1, 4'd1, 64'h0, 1'b1},
      '{16'hF200, 16'h0000, 64'h0,                  3'd2, 4'd0, 64'h0, 1'b1},
      '{16'hFE12, 16'h0000, 64'h0,                  3'd2, 4'd0, 64'h0, 1'b1},
      '{16'hF000, 16'h2200, ONES,                   3'd1, 4'd2, 64'h0, 1'b1},
      '{16'hF000, 16'h3000, ONES,                   3'd1, 4'd3, 64'h0, 1'b1},
      '{16'hF000, 16'hA000, ONES,                   3'd1, 4'd4, 64'h0, 1'b1},
      '{16'hF000, 16'h2800, ONES,                   3'd1, 4'd3, 64'h0, 1'b1},
      '{16'hF000, 16'h2C03, ONES,                   3'd1, 4'd3, 64'h0, 1'b1},
      '{16'hF000, 16'h9F00, ONES,                   3'd1, 4'd7, 64'h0, 1'b1},
      '{16'hF000, 16'h0200, 64'h0,                  3'd0, 4'd8, 64'h0000_0000_8000_1234, 1'b1},
      '{16'hF013, 16'h0000, 64'h0000_0000_7FFF_FFFF, 3'd0, 4'd8, 64'h0, 1'b0},
      '{16'hF014, 16'h4200, 64'h0,                  3'd0, 4'd8, 64'h0000_0000_7FFF_FFFF, 1'b0}
   };

   function automatic string tag_of(int i);
      case (i)
         0, 24:             return "R8";
         1:                 return "R5";
         2, 3, 5:           return "R7";
         4, 6, 7, 11, 12, 25: return "R4";
         8, 9, 10:          return "R6";
         13, 14:            return "R1";
         15, 16:            return "R2";
         default:           return "R3";
      endcase
   endfunction

   task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog R10 actual=timeout expected=completion");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11: reset state
      chk("R11", "done", {63'b0, done}, 64'h0);
      chk("R11", "outcome", {61'b0, outcome}, 64'h0);
      chk("R11", "kind", {60'b0, cmd_kind}, 64'h0);
      chk("R11", "rd_data", rd_data, 64'h0);
      chk("R11", "ea", {58'b0, ea_field}, 64'h0);
      chk("R11", "enable", {63'b0, mmu_enable}, 64'h0);

      for (int i = 0; i < NV; i++) begin
         cmd_valid = 1'b1;
         opcode    = VECS[i].opc;
         ext_word  = VECS[i].ext;
         wr_data   = VECS[i].wd;
         @(negedge clk);
         chk(tag_of(i), "outcome", {61'b0, outcome}, {61'b0, VECS[i].out});
         chk(tag_of(i), "kind", {60'b0, cmd_kind}, {60'b0, VECS[i].kind});
         chk(tag_of(i), "rd_data", rd_data, VECS[i].rd);
         chk(tag_of(i), "enable", {63'b0, mmu_enable}, {63'b0, VECS[i].en});
         chk("R9", "ea", {58'b0, ea_field}, {58'b0, VECS[i].opc[5:0]});
         chk("R10", "done", {63'b0, done}, 64'h1);
      end

      // R10: done drops the cycle after the command stream ends
      cmd_valid = 1'b0;
      wr_data   = ONES;
      @(negedge clk);
      chk("R10", "done low", {63'b0, done}, 64'h0);
      chk("R8", "enable held", {63'b0, mmu_enable}, 64'h0);

      // R8: set enable again, hold with no command
      cmd_valid = 1'b1; opcode = 16'hF001; ext_word = 16'h0000; wr_data = 64'h0000_0000_8000_0000;
      @(negedge clk);
      chk("R8", "enable set", {63'b0, mmu_enable}, 64'h1);
      cmd_valid = 1'b0;
      @(negedge clk);
      chk("R8", "enable kept", {63'b0, mmu_enable}, 64'h1);

      // R11: reset clears registers
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      chk("R11", "enable after reset", {63'b0, mmu_enable}, 64'h0);
      cmd_valid = 1'b1; opcode = 16'hF000; ext_word = 16'h0A00; wr_data = '0;
      @(negedge clk);
      chk("R11", "root cleared", rd_data, 64'h0);
      cmd_valid = 1'b0;
      @(negedge clk);

      finished = 1'b1;
      summary();
      $finish;
   end

endmodule